// File: doc/BRIEF.md
# Banked Scratchpad Conflict Resolver

This block fronts a word-addressed scratchpad split into `NBANKS` banks that are each one dword wide. A request carries one dword address per lane, a per-lane enable mask and a single read or write direction. The resolver finds the banks that more than one distinct address wants in the same cycle. It then runs the request as a series of single-cycle passes. In each pass every bank serves at most one address. All pending lanes that ask for that exact address ride along as a broadcast. Colliding requests therefore finish with correct results and simply take more cycles.

The request side is a valid/ready handshake. `req_ready` is high only while the block is idle, and a request is taken on a clock edge where `req_valid` and `req_ready` are both high. The response side is also valid/ready. `rsp_valid` rises when the last pass is done. `rsp_rdata` and `rsp_passes` then hold still until `rsp_ready` is seen high on an edge, and the block goes back to idle on that edge. `busy` is high from acceptance until the response is taken. `pass_bank_en` shows which banks are accessed in the current pass. With the default `ROWS` = 64 the storage is 8 KB. Setting `ROWS` = 512 gives the full 64 KB over 32 banks.

Top module: `lds_conflict_resolver`

## Requirements
- R1: `req_ready` is 1 exactly when the block is idle. A request is accepted on an edge with `req_valid` and `req_ready` both high. While busy, `req_valid` is ignored.
- R2: Address bits [BW-1:0] (BW = log2 NBANKS, 5 by default) select the bank, and the remaining upper bits select the row. Two addresses that differ by a multiple of `NBANKS` therefore share a bank.
- R3: The number of passes, both as cycles from acceptance to `rsp_valid` and as the value on `rsp_passes`, equals the largest count of distinct addresses among the enabled lanes that map to any one bank. A request with no enabled lane takes 0 passes.
- R4: Enabled lanes that read the identical address are served in the same pass and all receive the same data.
- R5: In each pass, every bank that still has a pending lane is accessed at the address of its lowest-numbered pending lane. `pass_bank_en` has a 1 at bit b for each bank accessed in that pass.
- R6: When several enabled lanes write the same address, the highest-numbered lane's data is stored.
- R7: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid`, `rsp_rdata` and `rsp_passes` hold their values.
- R8: A disabled lane neither writes storage nor reads it: its `rsp_rdata` slot is 0. For a write request, every slot is 0.
- R9: A read returns the data most recently written to that address by an earlier request.
- R10: After reset the block is idle: `req_ready`=1, `busy`=0, `rsp_valid`=0, `pass_bank_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_lane_en | input | LANES | Per-lane enable |
| req_addr | input | LANES*AW | Dword address, lane i at [i*AW +: AW] |
| req_wdata | input | LANES*DW | Write data, lane i at [i*DW +: DW] |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_rdata | output | LANES*DW | Read data per lane, lane i at [i*DW +: DW] |
| rsp_passes | output | PCW | Number of passes the request needed |
| busy | output | 1 | Request in flight or response not yet taken |
| pass_bank_en | output | NBANKS | Banks accessed in the current pass |

## Verification
The hardest situation to reach is a mix in which one bank holds repeated and distinct addresses together while another bank needs a different number of passes. This is the case where a broadcast must be merged while a conflict is still being serialised. The stimulus builds this directly. Lanes 0 to 3 target one bank with rows 0,1,0,2, and lanes 4 to 7 target another bank with rows 4,4,4,5. The same pattern is first written, which also exercises the same-address write winner, and then read back. Back-pressure is reached by holding `rsp_ready` low for several cycles while a second request is offered.

// File: rtl/lds_res_pkg.sv
package lds_res_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_RESP = 2'd2
  } res_state_e;

endpackage

// File: rtl/lds_pass_picker.sv
module lds_pass_picker #(
  parameter int LANES  = 8,
  parameter int NBANKS = 32,
  parameter int ROWS   = 64,
  parameter int DW     = 32,
  localparam int BW    = $clog2(NBANKS),
  localparam int RW    = $clog2(ROWS),
  localparam int AW    = BW + RW
) (
  input  logic [LANES-1:0]     pending,
  input  logic [LANES*AW-1:0]  addr,
  input  logic [LANES*DW-1:0]  wdata,
  output logic [NBANKS-1:0]    bank_en,
  output logic [NBANKS*RW-1:0] bank_row,
  output logic [NBANKS*DW-1:0] bank_wdata,
  output logic [LANES-1:0]     served
);

  logic [BW-1:0] l_bank [LANES];
  logic [RW-1:0] l_row  [LANES];
  logic [DW-1:0] l_wd   [LANES];
  logic [RW-1:0] lead_row [NBANKS];
  logic [DW-1:0] lead_wd  [NBANKS];

  for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
    assign l_bank[gi] = addr[gi*AW +: BW];
    assign l_row[gi]  = addr[gi*AW+BW +: RW];
    assign l_wd[gi]   = wdata[gi*DW +: DW];
  end

  // leader per bank: lowest-numbered pending lane (descending scan, last hit wins)
  always_comb begin
    for (int b = 0; b < NBANKS; b++) begin
      bank_en[b]  = 1'b0;
      lead_row[b] = '0;
      for (int i = LANES - 1; i >= 0; i--) begin
        if (pending[i] && (l_bank[i] == BW'(b))) begin
          bank_en[b]  = 1'b1;
          lead_row[b] = l_row[i];
        end
      end
    end
  end

  // a lane rides along when its row matches the leader of its bank
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      served[i] = pending[i] && (lead_row[l_bank[i]] == l_row[i]);
    end
  end

  // write data per bank: highest-numbered served lane (ascending scan)
  always_comb begin
    for (int b = 0; b < NBANKS; b++) begin
      lead_wd[b] = '0;
      for (int i = 0; i < LANES; i++) begin
        if (served[i] && (l_bank[i] == BW'(b))) begin
          lead_wd[b] = l_wd[i];
        end
      end
    end
  end

  for (genvar gb = 0; gb < NBANKS; gb++) begin : g_pack
    assign bank_row[gb*RW +: RW]   = lead_row[gb];
    assign bank_wdata[gb*DW +: DW] = lead_wd[gb];
  end

endmodule

// File: rtl/lds_bank_array.sv
module lds_bank_array #(
  parameter int NBANKS = 32,
  parameter int ROWS   = 64,
  parameter int DW     = 32,
  localparam int RW    = $clog2(ROWS)
) (
  input  logic                 clk,
  input  logic [NBANKS-1:0]    we,
  input  logic [NBANKS*RW-1:0] row,
  input  logic [NBANKS*DW-1:0] wdata,
  output logic [NBANKS*DW-1:0] rdata
);

  for (genvar gb = 0; gb < NBANKS; gb++) begin : g_bank
    logic [DW-1:0] mem [ROWS];
    logic [RW-1:0] r_idx;

    assign r_idx = row[gb*RW +: RW];

    always_ff @(posedge clk) begin
      if (we[gb]) begin
        mem[r_idx] <= wdata[gb*DW +: DW];
      end
    end

    assign rdata[gb*DW +: DW] = mem[r_idx];
  end

endmodule

// File: rtl/lds_conflict_resolver.sv
module lds_conflict_resolver
  import lds_res_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int NBANKS = 32,
  parameter int ROWS   = 64,
  parameter int DW     = 32,
  localparam int BW    = $clog2(NBANKS),
  localparam int RW    = $clog2(ROWS),
  localparam int AW    = BW + RW,
  localparam int PCW   = $clog2(LANES + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [LANES-1:0]    req_lane_en,
  input  logic [LANES*AW-1:0] req_addr,
  input  logic [LANES*DW-1:0] req_wdata,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [LANES*DW-1:0] rsp_rdata,
  output logic [PCW-1:0]      rsp_passes,
  output logic                busy,
  output logic [NBANKS-1:0]   pass_bank_en
);

  res_state_e          state_q;
  logic [LANES-1:0]    pending_q;
  logic [LANES*AW-1:0] addr_q;
  logic [LANES*DW-1:0] wdata_q;
  logic                write_q;
  logic [PCW-1:0]      passes_q;
  logic [DW-1:0]       lane_rd [LANES];

  logic [LANES-1:0]     pend_eff;
  logic [LANES-1:0]     served;
  logic [LANES-1:0]     left_after;
  logic [NBANKS-1:0]    bank_en;
  logic [NBANKS-1:0]    bank_we;
  logic [NBANKS*RW-1:0] bank_row;
  logic [NBANKS*DW-1:0] bank_wdata;
  logic [NBANKS*DW-1:0] bank_rdata;
  logic [DW-1:0]        bank_rd_a [NBANKS];

  assign pend_eff   = (state_q == ST_RUN) ? pending_q : '0;
  assign left_after = pending_q & ~served;
  assign bank_we    = bank_en & {NBANKS{write_q}};

  lds_pass_picker #(
    .LANES(LANES), .NBANKS(NBANKS), .ROWS(ROWS), .DW(DW)
  ) u_picker (
    .pending    (pend_eff),
    .addr       (addr_q),
    .wdata      (wdata_q),
    .bank_en    (bank_en),
    .bank_row   (bank_row),
    .bank_wdata (bank_wdata),
    .served     (served)
  );

  lds_bank_array #(
    .NBANKS(NBANKS), .ROWS(ROWS), .DW(DW)
  ) u_banks (
    .clk   (clk),
    .we    (bank_we),
    .row   (bank_row),
    .wdata (bank_wdata),
    .rdata (bank_rdata)
  );

  for (genvar gb = 0; gb < NBANKS; gb++) begin : g_rd
    assign bank_rd_a[gb] = bank_rdata[gb*DW +: DW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      pending_q <= '0;
      addr_q    <= '0;
      wdata_q   <= '0;
      write_q   <= 1'b0;
      passes_q  <= '0;
      for (int i = 0; i < LANES; i++) lane_rd[i] <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            pending_q <= req_lane_en;
            addr_q    <= req_addr;
            wdata_q   <= req_wdata;
            write_q   <= req_write;
            passes_q  <= '0;
            for (int i = 0; i < LANES; i++) lane_rd[i] <= '0;
            state_q   <= (|req_lane_en) ? ST_RUN : ST_RESP;
          end
        end
        ST_RUN: begin
          pending_q <= left_after;
          passes_q  <= passes_q + 1'b1;
          if (!write_q) begin
            for (int i = 0; i < LANES; i++) begin
              if (served[i]) lane_rd[i] <= bank_rd_a[addr_q[i*AW +: BW]];
            end
          end
          if (left_after == '0) state_q <= ST_RESP;
        end
        ST_RESP: begin
          if (rsp_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready    = (state_q == ST_IDLE);
  assign busy         = (state_q != ST_IDLE);
  assign rsp_valid    = (state_q == ST_RESP);
  assign rsp_passes   = passes_q;
  assign pass_bank_en = bank_en;

  for (genvar gi = 0; gi < LANES; gi++) begin : g_out
    assign rsp_rdata[gi*DW +: DW] = lane_rd[gi];
  end

  // ---------------- assertions ----------------
  assert_accept_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);

  assert_pass_progress_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN) |-> (served != '0));

  assert_passes_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (32'(rsp_passes) <= 32'(LANES)));

  assert_served_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN) |-> ((served & ~pending_q) == '0));

  assert_rsp_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_passes)));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (pass_bank_en == '0));

endmodule

// File: tb/test_lds_conflict_resolver.sv
`timescale 1ns/1ps
module test_lds_conflict_resolver;

  localparam int LANES = 8, NBANKS = 32, ROWS = 64, DW = 32;
  localparam int BW = 5, RW = 6, AW = 11, PCW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b0;
  logic [LANES-1:0] req_lane_en = '0;
  logic [LANES*AW-1:0] req_addr = '0;
  logic [LANES*DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, busy;
  logic [LANES*DW-1:0] rsp_rdata;
  logic [PCW-1:0] rsp_passes;
  logic [NBANKS-1:0] pass_bank_en;

  always #2 clk = ~clk;

  lds_conflict_resolver #(.LANES(LANES), .NBANKS(NBANKS), .ROWS(ROWS), .DW(DW)) i_lds_conflict_resolver (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_lane_en(req_lane_en), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .rsp_passes(rsp_passes), .busy(busy),
    .pass_bank_en(pass_bank_en));

  int checks = 0;
  int fails = 0;
  logic [DW-1:0] model [NBANKS][ROWS];
  logic [AW-1:0] cur_addr [LANES];
  logic [DW-1:0] cur_data [LANES];

  task automatic chk(string req, bit ok, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] mk(int row, int bank);
    return {RW'(row), BW'(bank)};
  endfunction

  // hold: cycles to keep rsp_ready low while offering a stray request
  task automatic do_req(string tag, bit wr, logic [LANES-1:0] en, int hold);
    int exp_p, cyc, cnt;
    logic [NBANKS-1:0] exp_en, first_en;
    logic [LANES*DW-1:0] snap;
    exp_p = 0; exp_en = '0;
    for (int b = 0; b < NBANKS; b++) begin
      cnt = 0;
      for (int i = 0; i < LANES; i++) begin
        bit dup = 0;
        if (en[i] && cur_addr[i][BW-1:0] == BW'(b)) begin
          exp_en[b] = 1'b1;
          for (int j = 0; j < i; j++)
            if (en[j] && cur_addr[j] == cur_addr[i]) dup = 1;
          if (!dup) cnt++;
        end
      end
      if (cnt > exp_p) exp_p = cnt;
    end
    @(negedge clk);
    req_write = wr; req_lane_en = en;
    for (int i = 0; i < LANES; i++) begin
      req_addr[i*AW +: AW] = cur_addr[i];
      req_wdata[i*DW +: DW] = cur_data[i];
    end
    req_valid = 1'b1;
    chk({tag, " R1 ready when idle"}, req_ready == 1'b1, 64'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0;
    first_en = pass_bank_en;
    chk({tag, " R5 first-pass banks"}, first_en == (exp_p > 0 ? exp_en : '0), 64'(first_en), 64'(exp_en));
    cyc = 0;
    while (!rsp_valid && cyc < 100) begin
      cyc++;
      @(negedge clk);
    end
    chk({tag, " R3 pass cycles"}, cyc == exp_p, 64'(cyc), 64'(exp_p));
    chk({tag, " R3 rsp_passes"}, 32'(rsp_passes) == exp_p, 64'(rsp_passes), 64'(exp_p));
    for (int i = 0; i < LANES; i++) begin
      logic [DW-1:0] e;
      e = (!wr && en[i]) ? model[cur_addr[i][BW-1:0]][cur_addr[i][AW-1:BW]] : '0;
      chk($sformatf("%s R9/R4/R8 lane%0d data", tag, i), rsp_rdata[i*DW +: DW] === e,
          64'(rsp_rdata[i*DW +: DW]), 64'(e));
    end
    if (hold > 0) begin
      snap = rsp_rdata;
      req_valid = 1'b1; req_lane_en = '1; req_write = 1'b1;
      for (int k = 0; k < hold; k++) begin
        @(negedge clk);
        chk({tag, " R7 rsp held"}, rsp_valid && rsp_rdata == snap && 32'(rsp_passes) == exp_p,
            64'(rsp_valid), 1);
        chk({tag, " R1 ignored while busy"}, !req_ready && busy, 64'(req_ready), 0);
      end
      req_valid = 1'b0; req_write = wr; req_lane_en = en;
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk({tag, " R1 idle after response"}, req_ready && !rsp_valid && !busy, 64'(req_ready), 1);
    if (wr)
      for (int i = 0; i < LANES; i++)
        if (en[i]) model[cur_addr[i][BW-1:0]][cur_addr[i][AW-1:BW]] = cur_data[i];
  endtask

  task automatic t_reset();
    chk("R10 req_ready", req_ready == 1'b1, 64'(req_ready), 1);
    chk("R10 busy", busy == 1'b0, 64'(busy), 0);
    chk("R10 rsp_valid", rsp_valid == 1'b0, 64'(rsp_valid), 0);
    chk("R10 pass_bank_en", pass_bank_en == '0, 64'(pass_bank_en), 0);
  endtask

  task automatic t_spread();   // R2 R5 R9: distinct banks, one pass
    for (int i = 0; i < LANES; i++) begin
      cur_addr[i] = mk(i, i * 3); cur_data[i] = 32'hA000_0000 + i;
    end
    do_req("spread-wr", 1, '1, 0);
    do_req("spread-rd", 0, '1, 0);
  endtask

  task automatic t_same_bank();   // R2 R3: stride of 32 lands in one bank
    for (int i = 0; i < LANES; i++) begin
      cur_addr[i] = AW'(7 + 32 * i); cur_data[i] = 32'hB100_0000 + i * 17;
    end
    do_req("bank7-wr", 1, '1, 0);
    do_req("bank7-rd", 0, '1, 0);
  endtask

  task automatic t_broadcast();   // R4
    for (int i = 0; i < LANES; i++) cur_addr[i] = AW'(7 + 64);
    do_req("broadcast", 0, '1, 0);
  endtask

  task automatic t_mixed();   // R3 R4 R6
    int rows [LANES] = '{0, 1, 0, 2, 4, 4, 4, 5};
    for (int i = 0; i < LANES; i++) begin
      cur_addr[i] = mk(rows[i], i < 4 ? 1 : 9); cur_data[i] = 32'hC000_0000 + i;
    end
    do_req("mixed-wr", 1, '1, 0);
    do_req("mixed-rd", 0, '1, 0);
  endtask

  task automatic t_winner();   // R6: lane 7 wins
    for (int i = 0; i < LANES; i++) begin
      cur_addr[i] = mk(10, 20); cur_data[i] = 32'hD000_0000 + i;
    end
    do_req("winner-wr", 1, '1, 0);
    do_req("winner-rd", 0, '1, 0);
    chk("R6 lane7 data stored", model[20][10] == 32'hD000_0007, 64'(model[20][10]), 64'hD000_0007);
  endtask

  task automatic t_mask();   // R8
    for (int i = 0; i < LANES; i++) begin
      cur_addr[i] = mk(30 + i, 2 * i + 1); cur_data[i] = 32'hE000_0000 + i;
    end
    do_req("mask-fill", 1, '1, 0);
    for (int i = 0; i < LANES; i++) cur_data[i] = 32'hF000_0000 + i;
    do_req("mask-wr", 1, 8'h55, 0);
    do_req("mask-rd-all", 0, '1, 0);
    do_req("mask-rd-low", 0, 8'h0F, 0);
  endtask

  task automatic t_empty();   // R3: zero passes
    do_req("empty", 0, '0, 0);
  endtask

  task automatic t_backpressure();   // R1 R7
    for (int i = 0; i < LANES; i++) cur_addr[i] = AW'(7 + 32 * (i % 3));
    do_req("backpressure", 0, '1, 5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_spread();
    t_same_bank();
    t_broadcast();
    t_mixed();
    t_winner();
    t_mask();
    t_empty();
    t_backpressure();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule